// File: doc/BRIEF.md
# Watchdog Reset Supervisor with Memory-Select Gating

This block watches a processor's keep-alive line and pulls a system reset when the line goes quiet for too long. Time is measured in ticks of an external timebase strobe (`tick`), one cycle wide. A change in either direction on `kick_in` proves the software is alive and restarts the timeout count. If the timeout runs out, reset is asserted for a full pulse period and a fault flag drops low. The flag stays low until the next change on `kick_in`. While `kick_in` stays stuck, the block keeps issuing reset pulses, one per long timeout. A power-fail input also forces reset. Reset is held for as long as power-fail stays high, and then for one more full pulse period.

A two-bit `mode` input selects how the block is timed.

| `mode` | Behaviour |
| --- | --- |
| 0 or 3 | Fixed timing: a long timeout both after reset and during normal running. |
| 1 | Split timing: a long first window after every reset, then a short window once the first change on `kick_in` arrives. |
| 2 | Clock-count timing: separate tick counts for the normal timeout, the first timeout after reset, and the pulse. |

All periods are parameters counted in timebase ticks, so a simulation can scale them down.

The block also gates a memory select line (`mem_sel_in_n`, active low) so that a memory cannot be written while the system is unstable. During normal running, the output follows the input. Reset from power-up or from the watchdog blocks the path at once. Reset from a power failure leaves the path open for a short grace period, to let an access in progress finish. The grace period ends when the select goes inactive (high) or after `CUT_CYCLES` clock cycles, whichever comes first. The pins are plain control signals: there is no data stream, so there is no handshake and no back-pressure.

Top module: `wdsup_top`

## Requirements
- R1: After `rst_n` is released, `rst_out` is 1, `rst_out_n` is 0 and `wd_fault_n` is 1. The reset stays asserted for the mode's pulse length in ticks: `PULSE_TICKS` in modes 0, 1 and 3, and `CLK_PULSE_TICKS` in mode 2.
- R2: In mode 0 (and in mode 3, which acts the same), both the first window and the normal window are `LONG_TICKS`. A watchdog reset lasts `PULSE_TICKS`.
- R3: In mode 1, the window after each reset is `LONG_TICKS`. After the first change on `kick_in`, the window becomes `SHORT_TICKS`. The next reset reloads the long window.
- R4: In mode 2, the first window is `CLK_FIRST_TICKS`, the normal window is `CLK_NORM_TICKS` and the pulse is `CLK_PULSE_TICKS`.
- R5: When the watchdog expires, `wd_fault_n` falls in the same cycle that `rst_out` rises. It stays 0 until a change on `kick_in` reaches the block through a two-flop synchronizer, after which it returns to 1.
- R6: Changes on `kick_in` in either direction restart the count. Changes spaced closer than the window never produce a reset.
- R7: With `kick_in` held constant, reset pulses repeat. The time at 0 between pulses equals the first window.
- R8: While reset is inactive, `mem_sel_out_n` equals `mem_sel_in_n`. A power-up reset or a watchdog reset forces `mem_sel_out_n` to 1 in the same cycle that `rst_out` is 1.
- R9: `pwr_fail` high sets `rst_out` on the next clock and holds it. Once `pwr_fail` falls, the reset lasts one more full pulse length.
- R10: On a reset caused by power failure, `mem_sel_out_n` keeps following `mem_sel_in_n` for at most `CUT_CYCLES` cycles. The path is cut one cycle after `mem_sel_in_n` is seen high, if that comes sooner.
- R11: The timeout and pulse counters advance only in cycles where `tick` is 1. With `tick` held at 0, no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| mode | input | 2 | Timing mode select |
| kick_in | input | 1 | Asynchronous keep-alive line; both edges count |
| pwr_fail | input | 1 | Power-fail request, active high |
| mem_sel_in_n | input | 1 | Memory select from processor, active low |
| rst_out | output | 1 | System reset, active high |
| rst_out_n | output | 1 | System reset, active low |
| wd_fault_n | output | 1 | Watchdog fault flag, active low, latched |
| mem_sel_out_n | output | 1 | Gated memory select, active low |

## Verification
The assertions assume that `mode` changes only while `rst_n` is low and that every period parameter is at least one tick. The window bound and the expiry comparison rely on both of these. The stimulus sets `mode` only inside a reset sequence and uses fixed scaled-down periods. It spaces the random keep-alive toggles well inside the short window and randomizes `tick` and the memory select. Directed sequences then cover stuck inputs, a stalled timebase and both ways the grace period can end.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED  = 2'd0,
    MODE_SPLIT  = 2'd1,
    MODE_CLOCKS = 2'd2,
    MODE_SPARE  = 2'd3
  } wd_mode_e;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } sup_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic toggle_seen
);
  // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign toggle_seen = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/wdsup_timer.sv
module wdsup_timer
  import wdsup_pkg::*;
#(
  parameter int LONG_TICKS      = 1600,
  parameter int SHORT_TICKS     = 100,
  parameter int PULSE_TICKS     = 200,
  parameter int CLK_NORM_TICKS  = 1024,
  parameter int CLK_FIRST_TICKS = 4096,
  parameter int CLK_PULSE_TICKS = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       pwr_fail,
  input  logic [1:0] mode,
  output logic       rst_act,
  output logic       fault_n,
  output logic       pf_trip
);
  localparam int MAXT = max2(max2(max2(LONG_TICKS, SHORT_TICKS), max2(PULSE_TICKS, CLK_NORM_TICKS)),
                             max2(CLK_FIRST_TICKS, CLK_PULSE_TICKS));
  localparam int CW = $clog2(MAXT + 1);

  sup_state_e    state;
  logic [CW-1:0] wcnt, pcnt;
  logic          first_win;
  logic [CW-1:0] norm_len, first_len, pulse_len, win_len;

  always_comb begin
    case (wd_mode_e'(mode))
      MODE_SPLIT: begin
        norm_len  = CW'(SHORT_TICKS);
        first_len = CW'(LONG_TICKS);
        pulse_len = CW'(PULSE_TICKS);
      end
      MODE_CLOCKS: begin
        norm_len  = CW'(CLK_NORM_TICKS);
        first_len = CW'(CLK_FIRST_TICKS);
        pulse_len = CW'(CLK_PULSE_TICKS);
      end
      default: begin
        norm_len  = CW'(LONG_TICKS);
        first_len = CW'(LONG_TICKS);
        pulse_len = CW'(PULSE_TICKS);
      end
    endcase
    win_len = first_win ? first_len : norm_len;
  end

  assign rst_act = (state == ST_HOLD);
  assign pf_trip = (state == ST_RUN) && pwr_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HOLD;
      wcnt      <= '0;
      pcnt      <= '0;
      first_win <= 1'b1;
      fault_n   <= 1'b1;
    end else begin
      if (kick) fault_n <= 1'b1;
      case (state)
        ST_HOLD: begin
          wcnt      <= '0;
          first_win <= 1'b1;
          if (pwr_fail) begin
            pcnt <= '0;
          end else if (tick) begin
            if (pcnt >= pulse_len - 1'b1) begin
              state <= ST_RUN;
              pcnt  <= '0;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        default: begin
          if (pwr_fail) begin
            state <= ST_HOLD;
            pcnt  <= '0;
            wcnt  <= '0;
          end else if (kick) begin
            wcnt      <= '0;
            first_win <= 1'b0;
          end else if (tick) begin
            if (wcnt >= win_len - 1'b1) begin
              state   <= ST_HOLD;
              pcnt    <= '0;
              wcnt    <= '0;
              fault_n <= 1'b0;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_fault_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !kick) |=> !fault_n);

  assert_fault_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> fault_n);

  assert_pf_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> rst_act);

  assert_win_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (wcnt < win_len));

  assert_tick_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !kick && !pwr_fail) |=> ($stable(wcnt) && $stable(pcnt)));

endmodule

// File: rtl/wdsup_ce_gate.sv
module wdsup_ce_gate #(
  parameter int CUT_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_act,
  input  logic pf_trip,
  input  logic sel_in_n,
  output logic sel_out_n
);
  localparam int DW = $clog2(CUT_CYCLES + 1);

  logic          grace;
  logic [DW-1:0] dcnt;

  assign sel_out_n = (rst_act && !grace) ? 1'b1 : sel_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grace <= 1'b0;
      dcnt  <= '0;
    end else if (pf_trip) begin
      grace <= 1'b1;
      dcnt  <= '0;
    end else if (grace) begin
      if (!rst_act || sel_in_n || (dcnt >= DW'(CUT_CYCLES - 1))) grace <= 1'b0;
      else dcnt <= dcnt + 1'b1;
    end
  end

  assert_grace_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grace |-> rst_act);

  assert_grace_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grace && sel_in_n && !pf_trip) |=> !grace);

endmodule

// File: rtl/wdsup_top.sv
module wdsup_top #(
  parameter int LONG_TICKS      = 1600,
  parameter int SHORT_TICKS     = 100,
  parameter int PULSE_TICKS     = 200,
  parameter int CLK_NORM_TICKS  = 1024,
  parameter int CLK_FIRST_TICKS = 4096,
  parameter int CLK_PULSE_TICKS = 2048,
  parameter int CUT_CYCLES      = 12,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       kick_in,
  input  logic       pwr_fail,
  input  logic       mem_sel_in_n,
  output logic       rst_out,
  output logic       rst_out_n,
  output logic       wd_fault_n,
  output logic       mem_sel_out_n
);
  logic kick, rst_act, pf_trip;

  wdsup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(kick_in), .toggle_seen(kick)
  );

  wdsup_timer #(
    .LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS), .PULSE_TICKS(PULSE_TICKS),
    .CLK_NORM_TICKS(CLK_NORM_TICKS), .CLK_FIRST_TICKS(CLK_FIRST_TICKS),
    .CLK_PULSE_TICKS(CLK_PULSE_TICKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .pwr_fail(pwr_fail),
    .mode(mode), .rst_act(rst_act), .fault_n(wd_fault_n), .pf_trip(pf_trip)
  );

  wdsup_ce_gate #(.CUT_CYCLES(CUT_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n), .rst_act(rst_act), .pf_trip(pf_trip),
    .sel_in_n(mem_sel_in_n), .sel_out_n(mem_sel_out_n)
  );

  assign rst_out   = rst_act;
  assign rst_out_n = ~rst_act;

  // watchdog or power-up reset: memory select blocked at once
  assert_sel_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_out) && !$past(pwr_fail)) |-> mem_sel_out_n);

  assert_sel_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out |-> (mem_sel_out_n == mem_sel_in_n));

  assert_fault_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_fault_n) |-> $rose(rst_out));

endmodule

// File: tb/wdsup_top_bench.sv
module wdsup_top_bench;
  localparam int LONG_T = 40, SHORT_T = 10, PULSE_T = 16;
  localparam int CN_T = 24, CF_T = 64, CP_T = 32, CUT = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, kick_in = 1'b0;
  logic pwr_fail = 1'b0, mem_sel_in_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic rst_out, rst_out_n, wd_fault_n, mem_sel_out_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  wdsup_top #(
    .LONG_TICKS(LONG_T), .SHORT_TICKS(SHORT_T), .PULSE_TICKS(PULSE_T),
    .CLK_NORM_TICKS(CN_T), .CLK_FIRST_TICKS(CF_T), .CLK_PULSE_TICKS(CP_T),
    .CUT_CYCLES(CUT)
  ) u_wdsup_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .kick_in(kick_in),
    .pwr_fail(pwr_fail), .mem_sel_in_n(mem_sel_in_n), .rst_out(rst_out),
    .rst_out_n(rst_out_n), .wd_fault_n(wd_fault_n), .mem_sel_out_n(mem_sel_out_n)
  );

  function automatic int first_win(input int m);
    return (m == 2) ? CF_T : LONG_T;
  endfunction
  function automatic int norm_win(input int m);
    return (m == 1) ? SHORT_T : (m == 2) ? CN_T : LONG_T;
  endfunction
  function automatic int pulse_len(input int m);
    return (m == 2) ? CP_T : PULSE_T;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_level(input logic val, output int n);
    n = 0;
    while (rst_out === val && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic restart(input int m);
    @(negedge clk);
    rst_n = 1'b0; mode = 2'(m); pwr_fail = 1'b0; tick = 1'b1; mem_sel_in_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // stuck-input sequence, then one kick, for a given mode
  task automatic mode_sweep(input int m, input string req);
    int n;
    restart(m);
    count_level(1'b1, n); check(n == pulse_len(m), "R1 power-up pulse", n, pulse_len(m));
    count_level(1'b0, n); check(n == first_win(m), req, n, first_win(m));
    check(wd_fault_n == 1'b0, "R5 fault low on expiry", wd_fault_n, 0);
    check(mem_sel_out_n == 1'b1, "R8 select blocked in watchdog reset", mem_sel_out_n, 1);
    count_level(1'b1, n); check(n == pulse_len(m), req, n, pulse_len(m));
    count_level(1'b0, n); check(n == first_win(m), "R7 stuck input repeats", n, first_win(m));
    count_level(1'b1, n); check(n == pulse_len(m), "R7 stuck pulse", n, pulse_len(m));
    check(wd_fault_n == 1'b0, "R5 fault held after pulse", wd_fault_n, 0);
    kick_in = ~kick_in;
    count_level(1'b0, n); check(n == norm_win(m) + 3, req, n, norm_win(m) + 3);
    count_level(1'b1, n); check(n == pulse_len(m), req, n, pulse_len(m));
    count_level(1'b0, n); check(n == first_win(m), "R3 first window reloaded", n, first_win(m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int gap;
    bit bad;
    void'($urandom(32'd2024));

    restart(0);
    check(rst_out == 1'b1, "R1 rst_out after reset", rst_out, 1);
    check(rst_out_n == 1'b0, "R1 rst_out_n after reset", rst_out_n, 0);
    check(wd_fault_n == 1'b1, "R1 fault idle after reset", wd_fault_n, 1);
    check(mem_sel_out_n == 1'b1, "R8 select blocked at power-up", mem_sel_out_n, 1);

    mode_sweep(0, "R2 fixed mode timing");
    // fault clears after a kick passes the synchronizer
    kick_in = ~kick_in;
    repeat (3) @(negedge clk);
    #1 check(wd_fault_n == 1'b1, "R5 fault cleared by kick", wd_fault_n, 1);

    mode_sweep(1, "R3 split mode timing");
    mode_sweep(2, "R4 clock-count mode timing");

    restart(3);
    count_level(1'b1, n); check(n == PULSE_T, "R2 spare mode pulse", n, PULSE_T);
    count_level(1'b0, n); check(n == LONG_T, "R2 spare mode window", n, LONG_T);

    // random kicks, timebase and select (R6, R8, R11)
    restart(1);
    count_level(1'b1, n);
    gap = int'($urandom_range(1, SHORT_T - 4));
    bad = 1'b0;
    for (int i = 0; i < 600; i++) begin
      tick = 1'($urandom_range(0, 1));
      mem_sel_in_n = 1'($urandom_range(0, 1));
      gap--;
      if (gap == 0) begin
        kick_in = ~kick_in;
        gap = int'($urandom_range(1, SHORT_T - 4));
      end
      #1;
      if (rst_out !== 1'b0) bad = 1'b1;
      if (mem_sel_out_n !== mem_sel_in_n) begin
        check(1'b0, "R8 select pass-through", mem_sel_out_n, mem_sel_in_n);
      end
      @(negedge clk);
    end
    check(!bad, "R6 frequent kicks prevent reset", bad, 0);
    check(1'b1, "R8 select pass-through", 0, 0);

    // stalled timebase: no timeout (R11)
    tick = 1'b0; mem_sel_in_n = 1'b0; bad = 1'b0;
    for (int i = 0; i < 3 * LONG_T; i++) begin
      @(negedge clk);
      if (rst_out !== 1'b0) bad = 1'b1;
    end
    check(!bad, "R11 no timeout without ticks", bad, 0);
    tick = 1'b1;
    count_level(1'b0, n);
    check(n >= 1 && n <= SHORT_T + 3, "R11 count resumes with ticks", n, SHORT_T);
    count_level(1'b1, n);

    // power fail with grace running out (R9, R10)
    mem_sel_in_n = 1'b0; pwr_fail = 1'b1;
    @(negedge clk);
    check(rst_out == 1'b1, "R9 power fail asserts reset", rst_out, 1);
    n = 0;
    while (mem_sel_out_n == 1'b0 && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == CUT, "R10 grace length", n, CUT);
    repeat (20) @(negedge clk);
    check(rst_out == 1'b1, "R9 reset held during power fail", rst_out, 1);
    pwr_fail = 1'b0;
    count_level(1'b1, n); check(n == PULSE_T, "R9 pulse after power fail", n, PULSE_T);

    // power fail with select going inactive first (R10)
    pwr_fail = 1'b1;
    @(negedge clk);
    #1 check(mem_sel_out_n == 1'b0, "R10 select passes in grace", mem_sel_out_n, 0);
    mem_sel_in_n = 1'b1;
    #1 check(mem_sel_out_n == 1'b1, "R10 select follows high", mem_sel_out_n, 1);
    @(negedge clk);
    mem_sel_in_n = 1'b0;
    #1 check(mem_sel_out_n == 1'b1, "R10 select cut after inactive", mem_sel_out_n, 1);
    pwr_fail = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule